// File: doc/BRIEF.md
# Background Divider with Result Queue

This block lets a stack-machine core hand off unsigned divisions and keep executing while they complete. Each accepted request enters a radix-2 divider that works one quotient bit per pipeline stage, so a fresh request can be taken every cycle. Finished results wait in issue order in a small queue. Each queue entry belongs to one division and holds a quotient word and a remainder word.

The core pulls results with two read strobes, one for a quotient and one for a remainder. Each read returns one word on the same cycle. The block records which halves of the oldest entry have already been taken. An entry is released once both halves are read, or as soon as a read asks again for a half that was already taken. In that second case the read is served from the following division. A quotient-only program can therefore step through successive divisions without ever reading a remainder. Capacity counts divisions still in the pipeline as well as finished ones. When capacity is exhausted the block raises busy, and the core holds its request until busy drops.

Top module: `div_result_queue`

## Requirements
- R1: For unsigned 32-bit operands with a nonzero divisor, a quotient read returns floor(dividend/divisor) and a remainder read returns dividend mod divisor.
- R2: A zero divisor yields the quotient 0xFFFFFFFF, and the remainder equals the dividend.
- R3: One request is accepted on every rising edge where `req_valid_i` is high and `busy_o` is low. If a request is accepted at edge t, a read of its result stalls between edges t+31 and t+32 and is served without stall right after edge t+32.
- R4: Results are returned in the order the requests were accepted.
- R5: Reading both halves of the oldest entry, in either order, retires it. The next read then comes from the following division.
- R6: A quotient read while the oldest entry's quotient has already been read discards that entry, even if its remainder is unread. The read returns the next division's quotient.
- R7: A remainder read while the oldest entry's remainder has already been read discards that entry. The read returns the next division's remainder.
- R8: While 8 divisions are outstanding (in flight or waiting to be read), `busy_o` is high and a request is not accepted. Such a request leaves no entry behind.
- R9: A read whose target entry is absent or not yet complete drives `stall_o` high, returns 0 and changes no state. It completes once the data is present.
- R10: If both strobes are high in one cycle, only the quotient read is performed, and the remainder strobe is ignored.
- R11: After reset `busy_o` and `stall_o` are low, and `rd_data_o` is 0 in every cycle without a completing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Divide request, held while busy_o is high |
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 32 | Unsigned divisor |
| busy_o | output | 1 | Queue full, request not taken |
| rd_quo_i | input | 1 | Quotient read strobe |
| rd_rem_i | input | 1 | Remainder read strobe |
| rd_data_o | output | 32 | Word returned by the completing read |
| stall_o | output | 1 | Read strobed but target not available |

## Verification
The hardest condition to reach is full capacity while most entries are still inside the 32-stage pipeline. At that point busy must hold on work that has not finished yet. The bench issues eight requests on consecutive cycles and holds a ninth request against busy for several cycles. It then drains the queue and shows that the ninth request left no entry, because a further read stalls. Repeated same-half reads are mixed with both-half reads so that the discard path runs for both quotient and remainder while later entries are still arriving.

// File: rtl/drq_pkg.sv
package drq_pkg;
  localparam int unsigned DRQ_DATA_W = 32;
  localparam int unsigned DRQ_DEPTH  = 8;
endpackage

// File: rtl/drq_div_stage.sv
module drq_div_stage #(
  parameter int unsigned W     = 32,
  parameter int unsigned TAG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [W-1:0]     rem_i,
  input  logic [W-1:0]     quo_i,
  input  logic [W-1:0]     dvs_i,
  output logic             v_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [W-1:0]     rem_o,
  output logic [W-1:0]     quo_o,
  output logic [W-1:0]     dvs_o
);
  logic [W:0]   trial, diff;
  logic         ge;
  logic [W-1:0] rem_n;

  // restoring step: bring in next dividend bit, subtract if it fits
  always_comb begin
    trial = {rem_i, quo_i[W-1]};
    diff  = trial - {1'b0, dvs_i};
    ge    = trial >= {1'b0, dvs_i};
    rem_n = ge ? diff[W-1:0] : trial[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_o <= 1'b0;
    else         v_o <= v_i;
  end

  always_ff @(posedge clk_i) begin
    tag_o <= tag_i;
    rem_o <= rem_n;
    quo_o <= {quo_i[W-2:0], ge};
    dvs_o <= dvs_i;
  end
endmodule

// File: rtl/drq_div_pipe.sv
module drq_div_pipe #(
  parameter int unsigned W     = 32,
  parameter int unsigned TAG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_v_i,
  input  logic [TAG_W-1:0] in_tag_i,
  input  logic [W-1:0]     dividend_i,
  input  logic [W-1:0]     divisor_i,
  output logic             out_v_o,
  output logic [TAG_W-1:0] out_tag_o,
  output logic [W-1:0]     out_quo_o,
  output logic [W-1:0]     out_rem_o
);
  localparam int unsigned STAGES = W;

  logic             v_s   [STAGES+1];
  logic [TAG_W-1:0] tag_s [STAGES+1];
  logic [W-1:0]     rem_s [STAGES+1];
  logic [W-1:0]     quo_s [STAGES+1];
  logic [W-1:0]     dvs_s [STAGES+1];

  assign v_s[0]   = in_v_i;
  assign tag_s[0] = in_tag_i;
  assign rem_s[0] = '0;
  assign quo_s[0] = dividend_i;
  assign dvs_s[0] = divisor_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    drq_div_stage #(.W(W), .TAG_W(TAG_W)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .v_i   (v_s[i]),
      .tag_i (tag_s[i]),
      .rem_i (rem_s[i]),
      .quo_i (quo_s[i]),
      .dvs_i (dvs_s[i]),
      .v_o   (v_s[i+1]),
      .tag_o (tag_s[i+1]),
      .rem_o (rem_s[i+1]),
      .quo_o (quo_s[i+1]),
      .dvs_o (dvs_s[i+1])
    );
  end

  assign out_v_o   = v_s[STAGES];
  assign out_tag_o = tag_s[STAGES];
  assign out_quo_o = quo_s[STAGES];
  assign out_rem_o = rem_s[STAGES];
endmodule

// File: rtl/drq_result_fifo.sv
module drq_result_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  output logic [PTR_W-1:0] tail_o,
  output logic             full_o,
  input  logic             wr_v_i,
  input  logic [PTR_W-1:0] wr_tag_i,
  input  logic [W-1:0]     wr_quo_i,
  input  logic [W-1:0]     wr_rem_i,
  input  logic             rd_quo_i,
  input  logic             rd_rem_i,
  output logic [W-1:0]     rd_data_o,
  output logic             stall_o
);
  logic [W-1:0]     quo_mem [DEPTH];
  logic [W-1:0]     rem_mem [DEPTH];
  logic [DEPTH-1:0] done_q, used_q_q, used_r_q;
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  logic             want_q, want_r, want, skip, other_used, have, fire, retire;
  logic [PTR_W-1:0] sel;

  always_comb begin
    want_q     = rd_quo_i;
    want_r     = rd_rem_i & ~rd_quo_i;  // quotient wins on a collision
    want       = want_q | want_r;
    skip       = want_q ? used_q_q[head_q] : used_r_q[head_q];
    other_used = want_q ? used_r_q[head_q] : used_q_q[head_q];
    sel        = head_q + PTR_W'(skip);
    have       = (count_q > CNT_W'(skip)) && done_q[sel];
    fire       = want && have;
    retire     = fire && (skip || other_used);
    stall_o    = want && !have;
    rd_data_o  = !fire ? '0 : (want_q ? quo_mem[sel] : rem_mem[sel]);
  end

  assign tail_o = tail_q;
  assign full_o = count_q == CNT_W'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= '0;
      used_q_q <= '0;
      used_r_q <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      count_q  <= '0;
    end else begin
      if (wr_v_i) done_q[wr_tag_i] <= 1'b1;
      if (fire) begin
        if (retire) begin
          done_q[head_q]   <= 1'b0;
          used_q_q[head_q] <= 1'b0;
          used_r_q[head_q] <= 1'b0;
          head_q           <= head_q + 1'b1;
        end
        // mark the half just taken unless its entry is leaving
        if (!(retire && !skip)) begin
          if (want_q) used_q_q[sel] <= 1'b1;
          else        used_r_q[sel] <= 1'b1;
        end
      end
      if (alloc_i) tail_q <= tail_q + 1'b1;
      count_q <= count_q + CNT_W'(alloc_i) - CNT_W'(retire);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_v_i) begin
      quo_mem[wr_tag_i] <= wr_quo_i;
      rem_mem[wr_tag_i] <= wr_rem_i;
    end
  end
endmodule

// File: rtl/div_result_queue.sv
module div_result_queue
  import drq_pkg::*;
#(
  parameter int unsigned DATA_W = DRQ_DATA_W,
  parameter int unsigned DEPTH  = DRQ_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  input  logic              rd_quo_i,
  input  logic              rd_rem_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              stall_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic              full, accept, done_v;
  logic [PTR_W-1:0]  tail, done_tag;
  logic [DATA_W-1:0] done_quo, done_rem;

  assign accept = req_valid_i & ~full;
  assign busy_o = full;

  drq_div_pipe #(.W(DATA_W), .TAG_W(PTR_W)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_v_i    (accept),
    .in_tag_i  (tail),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .out_v_o   (done_v),
    .out_tag_o (done_tag),
    .out_quo_o (done_quo),
    .out_rem_o (done_rem)
  );

  drq_result_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alloc_i  (accept),
    .tail_o   (tail),
    .full_o   (full),
    .wr_v_i   (done_v),
    .wr_tag_i (done_tag),
    .wr_quo_i (done_quo),
    .wr_rem_i (done_rem),
    .rd_quo_i (rd_quo_i),
    .rd_rem_i (rd_rem_i),
    .rd_data_o(rd_data_o),
    .stall_o  (stall_o)
  );
endmodule

// File: rtl/drq_checker.sv
module drq_checker #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             busy_o,
  input logic             rd_quo_i,
  input logic             rd_rem_i,
  input logic             stall_o,
  input logic [W-1:0]     rd_data_o,
  input logic [CNT_W-1:0] count_i
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH)); // R8
  AST_BUSY_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i)); // R8
  AST_ONE_PER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == $past(count_i)) || (count_i == $past(count_i) + 1'b1)
    || (count_i + 1'b1 == $past(count_i))); // R3
  AST_EMPTY_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0 && (rd_quo_i || rd_rem_i)) |-> (stall_o && rd_data_o == '0)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_quo_i || rd_rem_i) |-> (!stall_o && rd_data_o == '0)); // R11
endmodule

bind div_result_queue drq_checker #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .busy_o     (busy_o),
  .rd_quo_i   (rd_quo_i),
  .rd_rem_i   (rd_rem_i),
  .stall_o    (stall_o),
  .rd_data_o  (rd_data_o),
  .count_i    (u_fifo.count_q)
);

// File: tb/tb_div_result_queue.sv
`timescale 1ns/1ps
module tb_div_result_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic        busy, rd_quo = 1'b0, rd_rem = 1'b0, stall;
  logic [31:0] rd_data;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { logic [31:0] q; logic [31:0] r; } res_t;
  res_t sb[$];
  bit   hq = 0, hr = 0;

  always #10 clk = ~clk;

  div_result_queue dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .dividend_i(dividend), .divisor_i(divisor), .busy_o(busy),
    .rd_quo_i(rd_quo), .rd_rem_i(rd_rem), .rd_data_o(rd_data), .stall_o(stall)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic res_t golden(logic [31:0] a, logic [31:0] b);
    res_t x;
    if (b == 0) begin x.q = 32'hFFFF_FFFF; x.r = a; end
    else begin x.q = a / b; x.r = a % b; end
    return x;
  endfunction

  // driver: issue one division, push expected result
  task automatic issue(logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    req_valid = 1'b1; dividend = a; divisor = b;
    #1;
    while (busy) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    sb.push_back(golden(a, b));
  endtask

  // expected word of the next read, per the retirement rules
  function automatic logic [31:0] model_read(bit q);
    logic [31:0] v;
    if (q ? hq : hr) begin void'(sb.pop_front()); hq = 0; hr = 0; end
    v = q ? sb[0].q : sb[0].r;
    if (q) hq = 1; else hr = 1;
    if (hq && hr) begin void'(sb.pop_front()); hq = 0; hr = 0; end
    return v;
  endfunction

  // monitor-side read: wait through stall, compare against scoreboard
  task automatic read(bit q, string req, bit both = 0);
    logic [31:0] exp;
    @(negedge clk);
    rd_quo = q | both; rd_rem = ~q | both;
    #1;
    while (stall) begin @(negedge clk); #1; end
    exp = model_read(q);
    check(req, rd_data, exp);
    @(posedge clk); #1;
    rd_quo = 1'b0; rd_rem = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R11 busy after reset", {31'b0, busy}, 0);
    check("R11 stall after reset", {31'b0, stall}, 0);
    check("R11 data idle", rd_data, 0);

    // R3 latency
    issue(32'd100, 32'd7);
    repeat (31) @(posedge clk);
    @(negedge clk); rd_quo = 1'b1; #1;
    check("R3 stall before t+32", {31'b0, stall}, 1);
    check("R9 data zero during stall", rd_data, 0);
    @(posedge clk); #1;
    check("R3 ready after t+32", {31'b0, stall}, 0);
    check("R1 quotient 100/7", rd_data, 32'd14);
    void'(model_read(1));
    @(posedge clk); #1; rd_quo = 1'b0;
    read(0, "R5 remainder 100/7");

    // R1 / R4 several patterns back to back, R2 zero divisor
    issue(32'hFFFF_FFFF, 32'd1);
    issue(32'd12345678, 32'd1000);
    issue(32'd5, 32'd9);
    issue(32'h8000_0000, 32'd3);
    issue(32'hDEAD_BEEF, 32'h0000_FFFF);
    issue(32'd7, 32'd7);
    issue(32'h0000_1234, 32'd0);
    for (int i = 0; i < 6; i++) begin
      read(1, "R1 R4 quotient");
      read(0, "R1 R4 remainder");
    end
    read(0, "R2 remainder zero divisor");
    read(1, "R2 quotient zero divisor");

    // R6 repeated quotient reads
    issue(32'd50, 32'd6);
    issue(32'd91, 32'd10);
    issue(32'd33, 32'd4);
    read(1, "R6 first quotient");
    read(1, "R6 skip to next quotient");
    read(0, "R6 remainder of second");
    read(1, "R6 third quotient");
    read(0, "R6 third remainder");

    // R7 repeated remainder reads
    issue(32'd77, 32'd5);
    issue(32'd1000, 32'd33);
    read(0, "R7 first remainder");
    read(0, "R7 skip to next remainder");
    read(1, "R7 quotient of second");

    // R10 both strobes
    issue(32'd29, 32'd4);
    read(1, "R10 both strobes give quotient", 1);
    read(0, "R10 remainder still available");

    // R8 capacity
    for (int i = 0; i < 8; i++) issue(32'd200 + i, 32'd3 + i);
    @(negedge clk);
    check("R8 busy at eight outstanding", {31'b0, busy}, 1);
    req_valid = 1'b1; dividend = 32'd999; divisor = 32'd2;
    repeat (5) begin
      @(negedge clk);
      check("R8 busy holds", {31'b0, busy}, 1);
    end
    req_valid = 1'b0;
    repeat (40) @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      read(1, "R8 R4 drain quotient");
      read(0, "R8 R4 drain remainder");
    end

    // R9 empty read stalls, no extra entry left from the refused request
    @(negedge clk); rd_quo = 1'b1;
    repeat (3) begin
      #1;
      check("R9 R8 empty read stalls", {31'b0, stall}, 1);
      check("R9 empty read data", rd_data, 0);
      @(negedge clk);
    end
    rd_quo = 1'b0;
    #1 check("R11 idle after stall", {31'b0, stall}, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule